// File: doc/BRIEF.md
# Serial Glitch-Free Output Stop Controller

This block lets software turn individual clock outputs of a clock distribution chip on and off over a two-wire serial link, without ever producing a shortened pulse. A free-running serial clock samples a data line. Each transfer is a single low start bit followed by twelve enable bits, one for each gateable output clock. Once all twelve bits have arrived, the word becomes the active enable set. A zero in a position stops that clock, and a one lets it run.

Each enable bit crosses into the domain of its own output clock through a two-flop synchroniser. It is then captured on the falling edge of that clock, so the gate opens or closes only while the clock is low. A stopped clock rests at logic 0, and every high pulse that leaves the block is a full-width copy of the raw clock's high phase. The first bank C output and the feedback clock bypass this block entirely.

Top module: `stopctl_top`

## Requirements
- R1: The receiver is idle while the data line is high. A low sampled on a rising serial clock edge while idle is a start bit, and the next 12 rising edges each sample one enable bit. The receiver then returns to idle.
- R2: The first bit after the start bit controls `clk_gated[0]`, and each later bit controls the next index up to `clk_gated[11]`. The order by bank is A0, A1, A2, A3, B0, B1, B2, B3, C1, C2, C3, SYNC.
- R3: An enable bit value of 1 lets the matching output follow its raw clock.
- R4: An enable bit value of 0 stops the matching output, which is then held at logic 0.
- R5: An output changes only at an edge of its own raw clock. Every high pulse it emits lasts exactly one full high phase of the raw clock, so no runt pulses occur.
- R6: After reset every enable bit is 1, so all outputs run.
- R7: The active enable set changes only when the 12th bit of a frame is sampled. A frame cut short by reset has no effect.
- R8: Each enable passes through `SYNC_STAGES` flops on rising edges of its raw clock and is then captured on that clock's falling edge. A new setting therefore shows up within `SYNC_STAGES`+1 raw periods of the frame's last bit.
- R9: A start bit sampled on the edge right after a frame's last bit begins a new frame with no idle gap, and the second frame takes effect.
- R10: A data line held high while idle leaves the enable set unchanged for as long as it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_serial | input | 1 | Free-running serial clock; data is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset, held across several periods of every clock |
| ser_data | input | 1 | Serial data line: start bit then 12 enable bits, high when idle |
| clk_raw | input | 12 | Ungated output clocks, index 0 = A0 through 11 = SYNC |
| clk_gated | output | 12 | Gated output clocks, same index order |

## Verification
The assertions watch the receiver on every serial clock edge. They check that the bit index stays within the frame, that a start bit opens a frame at index zero, and that the receiver returns to idle after the 12th bit. They also check that the enable word changes only on that 12th bit. In each output domain, they check that the falling-edge stage takes the synchronised value and that a closed gate holds its output low. Only the bench scenarios can show the full serial-to-clock result. These cover the bit-to-output mapping, the settle time across the crossing, back-to-back frames, long idle, and reset in mid-frame. The bench also measures every emitted high pulse against the raw high phase to confirm that no runt pulse appears.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

    localparam int unsigned GATED_OUTS = 12;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_DATA = 1'b1
    } rx_state_e;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/stopctl_rx.sv
module stopctl_rx
    import stopctl_pkg::*;
#(
    parameter int unsigned N  = GATED_OUTS,
    parameter int unsigned IW = idx_bits(GATED_OUTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sd,
    output logic [N-1:0]  en_word,
    output logic          busy,
    output logic [IW-1:0] idx
);

    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    typedef struct packed {
        rx_state_e     state;
        logic [IW-1:0] pos;
        logic [N-1:0]  shadow;
    } rx_ctx_t;

    rx_ctx_t      ctx;
    rx_ctx_t      ctx_nx;
    logic [N-1:0] word_nx;
    logic         commit;

    always_comb begin
        ctx_nx  = ctx;
        word_nx = ctx.shadow;
        commit  = 1'b0;
        word_nx[ctx.pos] = sd;
        case (ctx.state)
            RX_IDLE: begin
                if (!sd) begin
                    ctx_nx.state = RX_DATA;
                    ctx_nx.pos   = '0;
                end
            end
            RX_DATA: begin
                ctx_nx.shadow = word_nx;
                if (ctx.pos == LAST_IDX) begin
                    commit       = 1'b1;
                    ctx_nx.state = RX_IDLE;
                    ctx_nx.pos   = '0;
                end else begin
                    ctx_nx.pos = ctx.pos + 1'b1;
                end
            end
            default: ctx_nx.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.state  <= RX_IDLE;
            ctx.pos    <= '0;
            ctx.shadow <= '1;
            en_word    <= '1;
        end else begin
            ctx <= ctx_nx;
            if (commit) begin
                en_word <= word_nx;
            end
        end
    end

    assign busy = (ctx.state == RX_DATA);
    assign idx  = ctx.pos;

endmodule

// File: rtl/stopctl_gate.sv
module stopctl_gate #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_raw,
    input  logic rst,
    input  logic en_async,
    output logic en_sync,
    output logic en_held,
    output logic clk_gated
);

    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk_raw) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], en_async};
        end
    end

    assign en_sync = sync_q[SYNC_STAGES-1];

    always_ff @(negedge clk_raw) begin
        if (rst) begin
            en_held <= 1'b1;
        end else begin
            en_held <= en_sync;
        end
    end

    assign clk_gated = clk_raw & en_held;

endmodule

// File: rtl/stopctl_top.sv
module stopctl_top
    import stopctl_pkg::*;
#(
    parameter int unsigned N_OUT       = GATED_OUTS,
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
    input  logic             clk_serial,
    input  logic             rst,
    input  logic             ser_data,
    input  logic [N_OUT-1:0] clk_raw,
    output logic [N_OUT-1:0] clk_gated
);

    localparam int unsigned IDX_W = idx_bits(N_OUT);

    logic [N_OUT-1:0] en_word;
    logic [N_OUT-1:0] en_sync;
    logic [N_OUT-1:0] en_held;
    logic             rx_busy;
    logic [IDX_W-1:0] rx_idx;

    stopctl_rx #(
        .N  (N_OUT),
        .IW (IDX_W)
    ) u_rx (
        .clk     (clk_serial),
        .rst     (rst),
        .sd      (ser_data),
        .en_word (en_word),
        .busy    (rx_busy),
        .idx     (rx_idx)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
        stopctl_gate #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_gate (
            .clk_raw   (clk_raw[g]),
            .rst       (rst),
            .en_async  (en_word[g]),
            .en_sync   (en_sync[g]),
            .en_held   (en_held[g]),
            .clk_gated (clk_gated[g])
        );
    end

endmodule

// File: rtl/stopctl_check.sv
module stopctl_check #(
    parameter int unsigned N  = 12,
    parameter int unsigned IW = 4
) (
    input logic          clk_serial,
    input logic          rst,
    input logic          ser_data,
    input logic [N-1:0]  clk_raw,
    input logic [N-1:0]  clk_gated,
    input logic [N-1:0]  en_word,
    input logic [N-1:0]  en_sync,
    input logic [N-1:0]  en_held,
    input logic          rx_busy,
    input logic [IW-1:0] rx_idx
);

    p_idx_bound_r1: assert property (@(posedge clk_serial) disable iff (rst)
        rx_busy |-> (rx_idx <= IW'(N - 1)));

    p_start_opens_r1: assert property (@(posedge clk_serial) disable iff (rst)
        (!rx_busy && !ser_data) |=> (rx_busy && rx_idx == '0));

    p_frame_end_r9: assert property (@(posedge clk_serial) disable iff (rst)
        (rx_busy && rx_idx == IW'(N - 1)) |=> !rx_busy);

    p_commit_last_r7: assert property (@(posedge clk_serial) disable iff (rst)
        (en_word != $past(en_word)) |-> ($past(rx_busy) && $past(rx_idx) == IW'(N - 1)));

    for (genvar g = 0; g < N; g++) begin : g_out
        p_low_phase_take_r8: assert property (@(negedge clk_raw[g]) disable iff (rst)
            clk_raw[g] |=> (en_held[g] == $past(en_sync[g])));

        p_stopped_low_r4: assert property (@(negedge clk_raw[g]) disable iff (rst)
            !en_held[g] |-> !clk_gated[g]);
    end

endmodule

bind stopctl_top stopctl_check #(
    .N  (N_OUT),
    .IW (IDX_W)
) u_stopctl_check (
    .clk_serial (clk_serial),
    .rst        (rst),
    .ser_data   (ser_data),
    .clk_raw    (clk_raw),
    .clk_gated  (clk_gated),
    .en_word    (en_word),
    .en_sync    (en_sync),
    .en_held    (en_held),
    .rx_busy    (rx_busy),
    .rx_idx     (rx_idx)
);

// File: tb/stopctl_top_test.sv
`timescale 1ns/1ps
module stopctl_top_test;

    localparam int N = 12;
    localparam int HALF0 = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_data = 1'b1;
    logic [N-1:0] clk_raw = '0;
    logic [N-1:0] clk_gated;

    int  n_checks = 0;
    int  n_fail = 0;
    int  rises [N];
    int  runts = 0;
    int  bad_width = 0;
    time t_edge [N];
    time t_rise [N];

    stopctl_top uut (
        .clk_serial (clk_serial_w),
        .rst        (rst),
        .ser_data   (ser_data),
        .clk_raw    (clk_raw),
        .clk_gated  (clk_gated)
    );

    wire clk_serial_w = clk;

    always #4 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_mon
        initial begin
            t_edge[g] = 0;
            t_rise[g] = 0;
            rises[g] = 0;
            forever begin
                #(HALF0 + g);
                t_edge[g] = $time;
                clk_raw[g] = ~clk_raw[g];
            end
        end
        always @(posedge clk_gated[g]) rises[g]++;
        always @(clk_gated[g]) begin
            if (!rst && $time > 0) begin
                if ($time != t_edge[g]) runts++;
                if (clk_gated[g] === 1'b1) begin
                    t_rise[g] = $time;
                end else if (clk_gated[g] === 1'b0 && t_rise[g] != 0) begin
                    if ($time - t_rise[g] != time'(HALF0 + g)) bad_width++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); #0.5 rst = 1'b1; ser_data = 1'b1;
        repeat (20) @(negedge clk);
        #0.5 rst = 1'b0;
        foreach (t_rise[i]) t_rise[i] = 0;
    endtask

    task automatic send_frame(input logic [N-1:0] w, input bit idle_after);
        @(negedge clk); ser_data = 1'b0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk); ser_data = w[i];
        end
        if (idle_after) begin
            @(negedge clk); ser_data = 1'b1;
        end
    endtask

    task automatic expect_word(input logic [N-1:0] w, input string req);
        #150;
        foreach (rises[i]) rises[i] = 0;
        #300;
        for (int i = 0; i < N; i++) begin
            if (w[i]) check(rises[i] > 0, req, rises[i], 1);
            else      check(rises[i] == 0 && clk_gated[i] == 1'b0, req, rises[i], 0);
        end
    endtask

    task automatic test_reset_default();
        do_reset();
        expect_word('1, "R6");
    endtask

    task automatic test_first_bit();
        send_frame(12'hFFE, 1'b1);
        expect_word(12'hFFE, "R2");
    endtask

    task automatic test_last_bit();
        send_frame(12'h7FF, 1'b1);
        expect_word(12'h7FF, "R2");
    endtask

    task automatic test_mixed();
        send_frame(12'h5A3, 1'b1);
        expect_word(12'h5A3, "R3");
    endtask

    task automatic test_stop_restart();
        send_frame(12'h000, 1'b1);
        expect_word(12'h000, "R4");
        send_frame(12'hFFF, 1'b1);
        expect_word(12'hFFF, "R3");
    endtask

    task automatic test_word_at_end();
        send_frame(12'h000, 1'b1);
        expect_word(12'h000, "R4");
        foreach (rises[i]) rises[i] = 0;
        @(negedge clk); ser_data = 1'b0;
        for (int i = 0; i < N - 1; i++) begin
            @(negedge clk); ser_data = 1'b1;
        end
        check(rises[0] == 0, "R7", rises[0], 0);
        check(rises[1] == 0, "R7", rises[1], 0);
        @(negedge clk); ser_data = 1'b1;
        @(negedge clk); ser_data = 1'b1;
        expect_word(12'hFFF, "R7");
    endtask

    task automatic test_back_to_back();
        send_frame(12'h000, 1'b0);
        send_frame(12'hC3C, 1'b1);
        expect_word(12'hC3C, "R9");
    endtask

    task automatic test_idle_hold();
        send_frame(12'h9E1, 1'b1);
        #600;
        expect_word(12'h9E1, "R10");
    endtask

    task automatic test_midframe_reset();
        send_frame(12'h000, 1'b1);
        expect_word(12'h000, "R4");
        @(negedge clk); ser_data = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ser_data = 1'b0;
        end
        do_reset();
        expect_word('1, "R7");
        send_frame(12'hF0F, 1'b1);
        expect_word(12'hF0F, "R1");
    endtask

    task automatic test_no_runt();
        check(runts == 0, "R5", runts, 0);
        check(bad_width == 0, "R5", bad_width, 0);
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset_default();
        test_first_bit();
        test_last_bit();
        test_mixed();
        test_stop_restart();
        test_word_at_end();
        test_back_to_back();
        test_idle_hold();
        test_midframe_reset();
        test_no_runt();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule